// File: doc/BRIEF.md
# Master Clock Rate Detector

This block works out which of three master clock rates a voice codec is running from, with no strap pin and no register to set. It relies on the fact that the transmit frame sync pulses at 8 kHz and the master clock is an exact integer multiple of that rate. The block counts master clock cycles between consecutive rising edges of the frame sync. A period of 256 cycles means 2.048 MHz, 512 means 4.096 MHz and 1024 means 8.192 MHz.

The frame sync first passes through a two-flop synchronizer. Rising edges are detected on the synchronized copy, so the pulse width has no effect. Each completed period is classified and drives a 2-bit rate code. A lock flag tells downstream timing logic that the code is stable and may be used to select a divide ratio. An error flag reports periods that match no supported rate, and a frame sync that has stopped.

The period counter saturates instead of wrapping. A missing frame sync therefore shows up as an error rather than as a false match. The reset is synchronous and active high.

Top module: `mclk_rate_detect`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rate_o` is 0, `locked_o` is 0 and `err_o` is 0.
- R2: A measured period of exactly 256 clock cycles between rising frame sync edges sets `rate_o` to 0 (2.048 MHz) and clears `err_o`.
- R3: A measured period of exactly 512 cycles sets `rate_o` to 1 (4.096 MHz), and exactly 1024 cycles sets `rate_o` to 2 (8.192 MHz). In both cases `err_o` is cleared.
- R4: `locked_o` rises only when a valid period is measured and the directly preceding measurement was valid with the same rate code. The first rising edge after reset only starts a count and changes no output.
- R5: A valid period whose code differs from the previous valid code clears `locked_o` and moves `rate_o` to the new code.
- R6: A period that matches none of the three values (for example 255, 257, 1023 or 1025) sets `err_o`, clears `locked_o` and leaves `rate_o` at its last valid value.
- R7: The period counter saturates at 2047. If no new rising edge arrives, `err_o` goes to 1 and `locked_o` goes to 0 on the 2049th clock edge after the edge that sampled the last rising frame sync. A period that is too long to count is measured as 2047 and treated as invalid.
- R8: The next valid measured period clears `err_o`.
- R9: Only rising edges of the frame sync delimit a frame. The high time of the pulse, from 1 cycle up to the period minus one, has no effect on any output.
- R10: The frame sync is sampled through two flops. Outputs reflecting a new measurement change on the third clock edge after the edge that first samples the frame sync high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| fs_i | input | 1 | Transmit frame sync, asynchronous to `clk` sampling |
| rate_o | output | 2 | Rate code: 0 = 2.048 MHz, 1 = 4.096 MHz, 2 = 8.192 MHz |
| locked_o | output | 1 | Two consecutive equal valid periods seen |
| err_o | output | 1 | Last period unsupported, or frame sync missing |

## Verification
The embedded assertions check on every cycle that lock and error are never high together, that the rate code stays below three, and that the counter holds at its ceiling. They also check that an unsupported measurement or a timeout clears lock and sets error on the next cycle while the code holds. The exact edge on which outputs update, the lock sequence across several frames, the 2049-edge timeout and the indifference to pulse width can only be shown by the bench. It runs directed frame sequences (near-miss periods, rate changes, a stalled sync) mixed with seeded random periods and pulse widths, against a frame-level model.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  // Nominal frame period, in master clocks, for rate index idx.
  function automatic int unsigned rate_period(input int unsigned base, input int unsigned idx);
    return base << idx;
  endfunction

endpackage

// File: rtl/mrd_sync.sv
module mrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic rise_o
);

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its one-cycle delay.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], d_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];

  // R9: a detected rise is one cycle wide, so one edge opens exactly one frame
  a_r9_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] meas_val_o,
  output logic             timeout_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      seen         <= 1'b0;
      meas_valid_o <= 1'b0;
      meas_val_o   <= '0;
      timeout_o    <= 1'b0;
    end else begin
      meas_valid_o <= rise_i & seen;
      timeout_o    <= !rise_i && (cnt == CNT_MAX - CNT_ONE);
      if (rise_i) begin
        meas_val_o <= cnt;
        cnt        <= CNT_ONE;
        seen       <= 1'b1;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  // R7: counter holds at its ceiling instead of wrapping
  a_r7_hold_at_max: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !rise_i) |=> (cnt == CNT_MAX));

  // R7: timeout is a single-cycle event
  a_r7_timeout_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);

  // R7: a measurement and a timeout never coincide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(timeout_o && meas_valid_o));

endmodule

// File: rtl/mrd_classify.sv
module mrd_classify #(
  parameter int BASE_PERIOD = 256,
  parameter int NUM_RATES   = 3,
  parameter int CNT_W       = 11,
  parameter int CODE_W      = 2
) (
  input  logic [CNT_W-1:0]  meas_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);

  logic [NUM_RATES-1:0] hit_vec;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    assign hit_vec[g] = (meas_i == CNT_W'(mrd_pkg::rate_period(BASE_PERIOD, g)));
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (hit_vec[i]) code_o = CODE_W'(i);
    end
    hit_o = |hit_vec;
  end

  // R2/R3: a count can match at most one supported rate
  always_comb begin
    a_r3_one_match: assert ($onehot0(hit_vec));
  end

endmodule

// File: rtl/mclk_rate_detect.sv
module mclk_rate_detect #(
  parameter int BASE_PERIOD = 256,
  parameter int NUM_RATES   = 3,
  parameter int CNT_W       = 11,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = $clog2(NUM_RATES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs_i,
  output logic [CODE_W-1:0] rate_o,
  output logic              locked_o,
  output logic              err_o
);

  logic              rise;
  logic              meas_valid;
  logic [CNT_W-1:0]  meas_val;
  logic              timeout;
  logic              hit;
  logic [CODE_W-1:0] cls_code;
  logic              prev_ok;

  mrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    (fs_i),
    .rise_o (rise)
  );

  mrd_period_counter #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst          (rst),
    .rise_i       (rise),
    .meas_valid_o (meas_valid),
    .meas_val_o   (meas_val),
    .timeout_o    (timeout)
  );

  mrd_classify #(
    .BASE_PERIOD (BASE_PERIOD),
    .NUM_RATES   (NUM_RATES),
    .CNT_W       (CNT_W),
    .CODE_W      (CODE_W)
  ) u_class (
    .meas_i (meas_val),
    .hit_o  (hit),
    .code_o (cls_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_o   <= '0;
      locked_o <= 1'b0;
      err_o    <= 1'b0;
      prev_ok  <= 1'b0;
    end else if (timeout) begin
      err_o    <= 1'b1;
      locked_o <= 1'b0;
      prev_ok  <= 1'b0;
    end else if (meas_valid) begin
      if (hit) begin
        locked_o <= prev_ok && (rate_o == cls_code);
        rate_o   <= cls_code;
        err_o    <= 1'b0;
        prev_ok  <= 1'b1;
      end else begin
        locked_o <= 1'b0;
        err_o    <= 1'b1;
        prev_ok  <= 1'b0;
      end
    end
  end

  // R6: lock and error are never reported together
  a_r6_lock_no_err: assert property (@(posedge clk) disable iff (rst)
    !(locked_o && err_o));

  // R6: an unsupported period drops lock, raises error, keeps the code
  a_r6_bad_period: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && !hit) |=> (err_o && !locked_o && $stable(rate_o)));

  // R4: lock only rises on a measurement
  a_r4_lock_on_meas: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(meas_valid));

  // R5: a change of code never leaves lock set
  a_r5_change_unlocks: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && hit && cls_code != rate_o) |=> !locked_o);

  // R7: a timeout raises error and drops lock
  a_r7_timeout_err: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (err_o && !locked_o));

  // R2/R3: code always names a supported rate
  a_r3_code_range: assert property (@(posedge clk) disable iff (rst)
    int'(rate_o) < NUM_RATES);

endmodule

// File: tb/test_mclk_rate_detect.sv
module test_mclk_rate_detect;

  localparam int CLK_PERIOD = 10;
  localparam int SAT        = 2047;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fs_i = 1'b0;
  logic [1:0] rate_o;
  logic       locked_o;
  logic       err_o;

  int total = 0;
  int bad   = 0;

  // frame-level model state
  bit m_seen, m_prev_ok, m_lock, m_err;
  int m_code;
  int prev_p = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclk_rate_detect i_mclk_rate_detect (
    .clk      (clk),
    .rst      (rst),
    .fs_i     (fs_i),
    .rate_o   (rate_o),
    .locked_o (locked_o),
    .err_o    (err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // code per supported period, -1 when unsupported
  function automatic int exp_code(input int p);
    if (p == 256)  return 0;
    if (p == 512)  return 1;
    if (p == 1024) return 2;
    return -1;
  endfunction

  task automatic frame(input int p, input int w);
    int  o_code, meas, c_exp;
    bit  o_lock, o_err, first;
    string ct, lt, et;
    o_code = m_code; o_lock = m_lock; o_err = m_err;
    first = !m_seen;
    if (first) begin
      m_seen = 1'b1;
      ct = "R9"; lt = "R4"; et = "R1";
    end else begin
      meas  = (prev_p > SAT) ? SAT : prev_p;
      c_exp = exp_code(meas);
      if (c_exp >= 0) begin
        m_lock    = m_prev_ok && (m_code == c_exp);
        m_code    = c_exp;
        m_err     = 1'b0;
        m_prev_ok = 1'b1;
        ct = (c_exp == 0) ? "R2" : "R3";
        lt = m_lock ? "R4" : "R5";
        et = "R8";
      end else begin
        m_lock = 1'b0; m_err = 1'b1; m_prev_ok = 1'b0;
        ct = "R6"; lt = "R6"; et = "R6";
      end
    end
    fs_i = 1'b1;
    for (int c = 1; c <= p; c++) begin
      @(negedge clk);
      if (c == w) fs_i = 1'b0;
      if (c == 3) begin
        // R10: nothing has moved yet
        chk("R10 rate early", int'(rate_o), o_code);
        chk("R10 lock early", int'(locked_o), int'(o_lock));
        chk("R10 err early", int'(err_o), int'(o_err));
      end
      if (c == 4) begin
        chk({ct, " rate"}, int'(rate_o), m_code);
        chk({lt, " lock"}, int'(locked_o), int'(m_lock));
        chk({et, " err"}, int'(err_o), int'(m_err));
        if (w > 1) chk("R9 wide pulse lock", int'(locked_o), int'(m_lock));
      end
      if (p > SAT + 10 && c == 2049) chk("R7 err before timeout", int'(err_o), int'(m_err));
      if (p > SAT + 10 && c == 2050) begin
        m_err = 1'b1; m_lock = 1'b0; m_prev_ok = 1'b0;
        chk("R7 err at timeout", int'(err_o), 1);
        chk("R7 lock at timeout", int'(locked_o), 0);
        chk("R7 rate held", int'(rate_o), m_code);
      end
    end
    prev_p = p;
  endtask

  initial begin
    int p, w, r, seed;
    seed = $urandom(32'd20240517);
    repeat (5) @(negedge clk);
    chk("R1 rate in reset", int'(rate_o), 0);
    chk("R1 lock in reset", int'(locked_o), 0);
    chk("R1 err in reset", int'(err_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rate after reset", int'(rate_o), 0);
    chk("R1 lock after reset", int'(locked_o), 0);
    chk("R1 err after reset", int'(err_o), 0);
    m_seen = 0; m_prev_ok = 0; m_lock = 0; m_err = 0; m_code = 0;

    // directed: lock at each rate, changes, near misses, timeout
    frame(256, 1); frame(256, 1); frame(256, 5); frame(256, 1);
    frame(512, 1);                        // R5 change drops lock
    frame(512, 100); frame(512, 1);       // R9 long pulse
    frame(1024, 1); frame(1024, 1); frame(255, 1);
    frame(257, 1); frame(1023, 1); frame(1025, 2);
    frame(1024, 1); frame(1024, 1);
    frame(2200, 3);                       // R7 stalled sync
    frame(256, 1); frame(256, 1); frame(256, 1);

    for (int i = 0; i < 60; i++) begin
      r = $urandom % 8;
      case (r)
        0, 1: p = 256;
        2, 3: p = 512;
        4:    p = 1024;
        5:    p = 8 + ($urandom % 1500);
        6:    p = (prev_p > 0 && prev_p < SAT) ? prev_p : 256;
        default: p = (256 << ($urandom % 3)) + (($urandom % 2) ? 1 : -1);
      endcase
      w = 1 + ($urandom % 8);
      if (w >= p) w = p - 1;
      frame(p, w);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 250000);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule